// File: doc/BRIEF.md
# Clock Driver Output Divider Stage

This block is the digital back end of a zero-delay clock buffer built around a phase-locked loop. It picks one of two sync clocks as the reference for the loop. It then clocks a small output stage from either the loop's oscillator or, in bypass, that same sync clock directly. The output stage can be preceded by an optional divide-by-two, and it drives a fan of related clocks: one double-rate output, a bank of in-phase outputs, one inverted output and one half-rate output. The oscillator is modelled as a plain clock input, and the lock flag comes in from the analog loop model.

All outputs come from one three-bit synchronous counter, so they all change on the same stage-clock edge and have no skew between them. Any of the in-phase outputs can be wired back to the loop's phase detector as the feedback clock. A single active-low input tri-states every clock output and clears the prescaler and the counter. When it goes high again, counting starts only after a short synchronous release, so the first output edges are clean and come in a known phase.

Top module: `clkdrv_out_stage`

## Requirements
- R1: `ref_clk_o` equals `sync_b_i` when `ref_sel_i` is 1 and `sync_a_i` when it is 0.
- R2: With `freq_sel_i` = 1, the stage clock advances once for every two rising edges of the path clock (the first rising edge after reset is a stage edge). With `freq_sel_i` = 0, every path-clock rising edge is a stage edge.
- R3: `lock_o` equals `lock_in_i` while `pll_en_i` is 1, and is 0 while `pll_en_i` is 0.
- R4: In normal mode (`pll_en_i` = 1) the path clock is `vco_clk_i`. `q2x_o` is bit 0, each `q_o` bit is bit 1 and `qhalf_o` is bit 2 of a counter that adds one on each counting stage edge. The three rates are therefore in the ratio 2 : 1 : 1/2.
- R5: All `q_o` bits are equal, and `qn_o` is their complement whenever outputs are driven.
- R6: In bypass mode (`pll_en_i` = 0) the path clock is the selected sync clock, and every clock output is the complement of its normal-mode value for the same counter state.
- R7: While `oe_rst_n_i` is 0, all eight clock outputs are high impedance. The prescaler, the release logic and the counter are cleared at once, without waiting for a clock.
- R8: After `oe_rst_n_i` rises, the counter holds 0 for the first two stage edges and increments from the third onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk_i | input | 1 | Oscillator clock from the analog loop |
| sync_a_i | input | 1 | Sync clock choice 0 |
| sync_b_i | input | 1 | Sync clock choice 1 |
| ref_sel_i | input | 1 | Selects sync_b_i when 1 |
| pll_en_i | input | 1 | 1 = oscillator path, 0 = bypass with the sync clock |
| freq_sel_i | input | 1 | 1 inserts the divide-by-two prescaler |
| oe_rst_n_i | input | 1 | Active-low output enable and divider reset |
| lock_in_i | input | 1 | Lock status from the analog loop |
| ref_clk_o | output | 1 | Selected reference to the phase detector |
| q2x_o | output | 1 | Double-rate clock, tri-state |
| q_o | output | NUM_Q | In-phase clocks, tri-state |
| qn_o | output | 1 | Inverted clock, tri-state |
| qhalf_o | output | 1 | Half-rate clock, tri-state |
| lock_o | output | 1 | Lock indication, low in bypass |

## Verification
The assertions assume that `pll_en_i`, `freq_sel_i` and `ref_sel_i` change only while `oe_rst_n_i` is low. A mode change while the stage runs would glitch the muxed clock, and the counter-step property would then not hold. The stimulus therefore changes modes only inside reset windows. It derives both sync clocks from edges of the bench clock, so every stage edge lands on a bench rising edge and the outputs are sampled cleanly at the falling edge. The bench reads the outputs through pulled-up nets, so a high-impedance output reads as 1. Each reset window is run in both modes, so that a driven 0 on some output can be told apart from a released line.

// File: rtl/clkdrv_pkg.sv
package clkdrv_pkg;
  localparam int CNT_W    = 3;
  localparam int IDX_2X   = 0;
  localparam int IDX_1X   = 1;
  localparam int IDX_HALF = 2;

  typedef struct packed {
    logic half;
    logic x1;
    logic x2;
  } rate_t;
endpackage

// File: rtl/clkdrv_path_sel.sv
module clkdrv_path_sel (
  input  logic vco_clk_i,
  input  logic sync_a_i,
  input  logic sync_b_i,
  input  logic ref_sel_i,
  input  logic pll_en_i,
  input  logic freq_sel_i,
  input  logic rst_n_i,
  output logic ref_clk_o,
  output logic path_clk_o,
  output logic pre_q_o,
  output logic stage_clk_o
);
  logic pre_d;

  // reference mux, then oscillator / bypass mux
  always_comb ref_clk_o  = ref_sel_i ? sync_b_i : sync_a_i;
  always_comb path_clk_o = pll_en_i ? vco_clk_i : ref_clk_o;

  // divide-by-two prescaler, enabled only when selected
  always_comb pre_d = ~pre_q_o;

  always_ff @(posedge path_clk_o or negedge rst_n_i) begin
    if (!rst_n_i)        pre_q_o <= 1'b0;
    else if (freq_sel_i) pre_q_o <= pre_d;
  end

  always_comb stage_clk_o = freq_sel_i ? pre_q_o : path_clk_o;
endmodule

// File: rtl/clkdrv_release.sv
module clkdrv_release #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic run_o
);
  logic [STAGES-1:0] rel_q;
  logic [STAGES-1:0] rel_d;

  always_comb rel_d = {rel_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rel_q <= '0;
    else          rel_q <= rel_d;
  end

  always_comb run_o = rel_q[STAGES-1];
endmodule

// File: rtl/clkdrv_rate_div.sv
module clkdrv_rate_div
  import clkdrv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output rate_t            rate_o
);
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = cnt_o + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   cnt_o <= '0;
    else if (run_i) cnt_o <= cnt_d;
  end

  always_comb begin
    rate_o.x2   = cnt_o[IDX_2X];
    rate_o.x1   = cnt_o[IDX_1X];
    rate_o.half = cnt_o[IDX_HALF];
  end
endmodule

// File: rtl/clkdrv_out_drv.sv
module clkdrv_out_drv
  import clkdrv_pkg::*;
#(
  parameter int NUM_Q = 5
) (
  input  rate_t            rate_i,
  input  logic             bypass_i,
  output logic             q2x_o,
  output logic [NUM_Q-1:0] q_o,
  output logic             qn_o,
  output logic             qhalf_o
);
  logic q_core;

  always_comb begin
    q2x_o   = rate_i.x2 ^ bypass_i;
    q_core  = rate_i.x1 ^ bypass_i;
    qhalf_o = rate_i.half ^ bypass_i;
    qn_o    = ~q_core;
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_qfan
    always_comb q_o[g] = q_core;
  end
endmodule

// File: rtl/clkdrv_out_stage.sv
module clkdrv_out_stage
  import clkdrv_pkg::*;
#(
  parameter int NUM_Q      = 5,
  parameter int REL_STAGES = 2
) (
  input  logic             vco_clk_i,
  input  logic             sync_a_i,
  input  logic             sync_b_i,
  input  logic             ref_sel_i,
  input  logic             pll_en_i,
  input  logic             freq_sel_i,
  input  logic             oe_rst_n_i,
  input  logic             lock_in_i,
  output logic             ref_clk_o,
  output wire              q2x_o,
  output wire [NUM_Q-1:0]  q_o,
  output wire              qn_o,
  output wire              qhalf_o,
  output logic             lock_o
);
  logic             path_clk;
  logic             pre_q;
  logic             stage_clk;
  logic             run;
  logic [CNT_W-1:0] cnt;
  rate_t            rate;
  logic             q2x_drv;
  logic [NUM_Q-1:0] q_drv;
  logic             qn_drv;
  logic             qhalf_drv;

  clkdrv_path_sel u_path (
    .vco_clk_i  (vco_clk_i),
    .sync_a_i   (sync_a_i),
    .sync_b_i   (sync_b_i),
    .ref_sel_i  (ref_sel_i),
    .pll_en_i   (pll_en_i),
    .freq_sel_i (freq_sel_i),
    .rst_n_i    (oe_rst_n_i),
    .ref_clk_o  (ref_clk_o),
    .path_clk_o (path_clk),
    .pre_q_o    (pre_q),
    .stage_clk_o(stage_clk)
  );

  clkdrv_release #(.STAGES(REL_STAGES)) u_rel (
    .clk_i  (stage_clk),
    .rst_n_i(oe_rst_n_i),
    .run_o  (run)
  );

  clkdrv_rate_div u_div (
    .clk_i  (stage_clk),
    .rst_n_i(oe_rst_n_i),
    .run_i  (run),
    .cnt_o  (cnt),
    .rate_o (rate)
  );

  clkdrv_out_drv #(.NUM_Q(NUM_Q)) u_drv (
    .rate_i  (rate),
    .bypass_i(~pll_en_i),
    .q2x_o   (q2x_drv),
    .q_o     (q_drv),
    .qn_o    (qn_drv),
    .qhalf_o (qhalf_drv)
  );

  assign q2x_o   = oe_rst_n_i ? q2x_drv   : 1'bz;
  assign q_o     = oe_rst_n_i ? q_drv     : {NUM_Q{1'bz}};
  assign qn_o    = oe_rst_n_i ? qn_drv    : 1'bz;
  assign qhalf_o = oe_rst_n_i ? qhalf_drv : 1'bz;

  always_comb lock_o = lock_in_i & pll_en_i;
endmodule

// File: rtl/clkdrv_out_stage_chk.sv
module clkdrv_out_stage_chk (
  input logic       vco_clk_i,
  input logic       path_clk,
  input logic       stage_clk,
  input logic       oe_rst_n_i,
  input logic       pll_en_i,
  input logic       freq_sel_i,
  input logic       lock_o,
  input logic       pre_q,
  input logic       run,
  input logic [2:0] cnt
);
  // R2: prescaler flips on every path edge when selected
  a_r2_pre_toggle: assert property (@(posedge path_clk) disable iff (!oe_rst_n_i)
    freq_sel_i |=> (pre_q != $past(pre_q)));

  // R3: no lock indication in bypass
  a_r3_lock_bypass: assert property (@(posedge vco_clk_i) disable iff (!oe_rst_n_i)
    !pll_en_i |-> !lock_o);

  // R4: counter steps by one per stage edge once running
  a_r4_count_step: assert property (@(posedge stage_clk) disable iff (!oe_rst_n_i)
    run |=> (cnt == $past(cnt) + 3'd1));

  // R8: counter is still zero when the release completes
  a_r8_release_zero: assert property (@(posedge stage_clk) disable iff (!oe_rst_n_i)
    $rose(run) |-> (cnt == 3'd0));
endmodule

bind clkdrv_out_stage clkdrv_out_stage_chk u_chk (
  .vco_clk_i (vco_clk_i),
  .path_clk  (path_clk),
  .stage_clk (stage_clk),
  .oe_rst_n_i(oe_rst_n_i),
  .pll_en_i  (pll_en_i),
  .freq_sel_i(freq_sel_i),
  .lock_o    (lock_o),
  .pre_q     (pre_q),
  .run       (run),
  .cnt       (cnt)
);

// File: tb/tb_clkdrv_out_stage.sv
`timescale 1ns/1ps
module tb_clkdrv_out_stage;
  localparam int NQ = 5;

  logic clk = 1'b0;
  logic sync_a = 1'b0, sync_b = 1'b0;
  logic ref_sel = 1'b0, pll_en = 1'b1, freq_sel = 1'b0;
  logic oe_rst_n = 1'b0, lock_in = 1'b0;
  logic ref_clk, lock;
  // pulled-up nets: a released output reads 1
  tri1 q2x, qn, qhalf;
  tri1 [NQ-1:0] q;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 1'b0;
  int ca = 0, cb = 0, lk = 0;

  clkdrv_out_stage #(.NUM_Q(NQ), .REL_STAGES(2)) dut (
    .vco_clk_i(clk), .sync_a_i(sync_a), .sync_b_i(sync_b),
    .ref_sel_i(ref_sel), .pll_en_i(pll_en), .freq_sel_i(freq_sel),
    .oe_rst_n_i(oe_rst_n), .lock_in_i(lock_in), .ref_clk_o(ref_clk),
    .q2x_o(q2x), .q_o(q), .qn_o(qn), .qhalf_o(qhalf), .lock_o(lock)
  );

  always #2 clk = ~clk;   // 250 MHz

  // slow sync clocks and lock status, all moving on bench rising edges
  always @(posedge clk) begin
    ca <= (ca == 2) ? 0 : ca + 1;
    if (ca == 2) sync_a <= ~sync_a;
    cb <= (cb == 4) ? 0 : cb + 1;
    if (cb == 4) sync_b <= ~sync_b;
    lk <= (lk == 6) ? 0 : lk + 1;
    if (lk == 6) lock_in <= ~lock_in;
  end

  // behavioural reference model
  logic m_path;
  assign m_path = pll_en ? clk : (ref_sel ? sync_b : sync_a);
  int m_pre = 0, m_rel = 0, m_cnt = 0;
  always @(posedge m_path or negedge oe_rst_n) begin
    bit se;
    if (!oe_rst_n) begin
      m_pre = 0; m_rel = 0; m_cnt = 0;
    end else begin
      se = 1'b1;
      if (freq_sel) begin m_pre = 1 - m_pre; se = (m_pre == 1); end
      if (se) begin
        if (m_rel >= 2) m_cnt = (m_cnt + 1) % 8;
        else            m_rel = m_rel + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) if (cmp_on) begin
    int pol, e2, e1, eh;
    string tag;
    chk("R1", "ref_clk", ref_clk, ref_sel ? sync_b : sync_a);
    chk("R3", "lock", lock, (pll_en && lock_in) ? 1 : 0);
    if (!oe_rst_n) begin
      chk("R7", "released outputs", {q2x, q, qn, qhalf}, {(NQ+3){1'b1}});
    end else begin
      pol = pll_en ? 0 : 1;
      e2 = (m_cnt & 1) ^ pol;
      e1 = ((m_cnt >> 1) & 1) ^ pol;
      eh = ((m_cnt >> 2) & 1) ^ pol;
      if (m_rel < 2)     tag = "R8";
      else if (freq_sel) tag = "R2";
      else if (!pll_en)  tag = "R6";
      else               tag = "R4";
      chk(tag, "q2x", q2x, e2);
      chk(tag, "q0", q[0], e1);
      chk(tag, "qhalf", qhalf, eh);
      chk("R5", "q bank", q, e1 ? {NQ{1'b1}} : 0);
      chk("R5", "qn", qn, 1 - e1);
    end
  end

  // edge counts for the rate window
  bit win = 1'b0;
  int n2 = 0, n1 = 0, nh = 0;
  always @(posedge q2x)   if (win) n2++;
  always @(posedge q[0])  if (win) n1++;
  always @(posedge qhalf) if (win) nh++;

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_reset(input bit pe, input bit fs, input bit rs);
    #1 oe_rst_n = 1'b0;
    waitn(2);
    pll_en = pe; freq_sel = fs; ref_sel = rs;
    waitn(4);
    #1 oe_rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      summary();
    end
  end

  initial begin
    waitn(2);
    cmp_on = 1'b1;
    waitn(8);                        // R7 reset state, normal mode
    hold_reset(1'b0, 1'b0, 1'b0);    // R7 reset state seen in bypass too
    #1 oe_rst_n = 1'b0; waitn(3);
    hold_reset(1'b1, 1'b0, 1'b0);    // R4 normal, no prescaler
    waitn(8);
    win = 1'b1; waitn(128); win = 1'b0;
    checks++;
    if (n2 < 2*n1 - 1 || n2 > 2*n1 + 1 || n1 < 2*nh - 1 || n1 > 2*nh + 1) begin
      errors++;
      $display("FAIL R4 rate ratio: actual=%0d/%0d/%0d expected=2:1:0.5", n2, n1, nh);
    end
    hold_reset(1'b1, 1'b1, 1'b1);    // R2 prescaler on
    waitn(150);
    #1 oe_rst_n = 1'b0;              // R7 asynchronous drop mid-run
    waitn(3);
    hold_reset(1'b0, 1'b0, 1'b0);    // R6 bypass on sync_a
    waitn(250);
    hold_reset(1'b0, 1'b1, 1'b1);    // R6/R2 bypass on sync_b with prescaler
    waitn(400);
    hold_reset(1'b1, 1'b0, 1'b1);    // R8 release again, normal
    waitn(40);
    summary();
  end
endmodule